// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip. Four test pins drive it: the test clock, the mode select, serial data in and an active-low asynchronous reset. It drives serial data out together with a flag that shows when that output carries valid data. Inside are the sixteen-state test port state machine, a three-bit instruction register and a one-bit bypass stage. The controller does not hold the boundary-scan chain itself. Instead it sends that external chain a select line and capture, shift and update strobes, and it takes the chain's serial output back in. A separate mode line tells the pin cells when to take the pads away from the core logic.

Three instructions are decoded. The first routes the boundary chain to the serial port and gives the pads to that chain's update latches. The second routes the chain so that it can sample the pads while the core keeps control of them. The third, like every other code, puts the single bypass bit between serial input and serial output. The controller is clocked only by the test clock. Its reset is asynchronous, because a test port has to recover even when no clock is running.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: While `trst_n` is low, and with no test clock edge needed, the controller is in its reset state. In that state `bsr_select`, `pin_override`, `tdo_en` and all three chain strobes are 0.
- R2: On entry to the instruction capture state, the instruction shift register loads the binary pattern 101. Shifting sends its least significant bit out first, so the first three bits seen on `tdo` are 1, 0, 1.
- R3: Opcode 000 (bit 0 shifted in first) is the external-drive instruction. It sets `bsr_select` = 1 and `pin_override` = 1.
- R4: Opcode 101 is the sample instruction. It sets `bsr_select` = 1 and `pin_override` = 0.
- R5: Opcode 111 selects bypass, and so do the unlisted codes 001, 010, 011, 100 and 110. Under bypass `bsr_select` = 0 and `pin_override` = 0. In the data path the bypass bit captures 0, so data reaches `tdo` delayed by one clock.
- R6: When `bsr_select` = 1 and the data shift state is active, `tdo` takes the value of `bsr_tdo` on the falling test clock edge.
- R7: `bsr_capture`, `bsr_shift` and `bsr_update` are high only in the data capture, data shift and data update states. Each is high only while `bsr_select` = 1, and never more than one of them at a time.
- R8: `tdo` changes only on the falling test clock edge. `tdo_en` is 1 only while the controller is in one of the two shift states.
- R9: Five consecutive rising test clock edges with `tms` = 1 bring the controller to its reset state from any state. That reset state restores the bypass instruction.
- R10: The active instruction changes only in the instruction update state, on the falling clock edge. A newly shifted code has no effect in the exit or pause states.
- R11: Asserting `trst_n` low in the middle of operation clears an active external-drive instruction at once, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select, sampled on the rising edge |
| tdi | input | 1 | Serial test data in, sampled on the rising edge |
| bsr_tdo | input | 1 | Serial output of the external boundary chain |
| tdo | output | 1 | Serial test data out, changes on the falling edge |
| tdo_en | output | 1 | High while `tdo` carries shift data |
| bsr_select | output | 1 | Boundary chain is the active data register |
| bsr_capture | output | 1 | Capture strobe for the boundary chain |
| bsr_shift | output | 1 | Shift strobe for the boundary chain |
| bsr_update | output | 1 | Update strobe for the boundary chain |
| pin_override | output | 1 | Pads are driven from the boundary update latches |

## Verification
The state machine, the instruction latch and the bypass bit can only be seen through the strobes, the mode lines and the shifted data. A wrong state therefore appears as a strobe in the wrong cycle, or as `tdo_en` rising one clock early or late. Both of these show on the next falling edge. A corrupted instruction latch appears at once on `bsr_select` and `pin_override`. A wrong capture value appears in the first `tdo` bit after a shift state is entered. A missing one-clock delay in bypass appears one bit into any data scan.

// File: rtl/tap_pkg.sv
package tap_pkg;

  typedef enum logic [3:0] {
    ST_RESET   = 4'd0,
    ST_IDLE    = 4'd1,
    ST_DR_SCAN = 4'd2,
    ST_DR_CAP  = 4'd3,
    ST_DR_SH   = 4'd4,
    ST_DR_EX1  = 4'd5,
    ST_DR_PAU  = 4'd6,
    ST_DR_EX2  = 4'd7,
    ST_DR_UPD  = 4'd8,
    ST_IR_SCAN = 4'd9,
    ST_IR_CAP  = 4'd10,
    ST_IR_SH   = 4'd11,
    ST_IR_EX1  = 4'd12,
    ST_IR_PAU  = 4'd13,
    ST_IR_EX2  = 4'd14,
    ST_IR_UPD  = 4'd15
  } tap_state_e;

  typedef enum logic [1:0] {
    INS_BYPASS = 2'd0,
    INS_SAMPLE = 2'd1,
    INS_DRIVE  = 2'd2
  } tap_ins_e;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RESET:   nxt = tms ? ST_RESET   : ST_IDLE;
      ST_IDLE:    nxt = tms ? ST_DR_SCAN : ST_IDLE;
      ST_DR_SCAN: nxt = tms ? ST_IR_SCAN : ST_DR_CAP;
      ST_DR_CAP:  nxt = tms ? ST_DR_EX1  : ST_DR_SH;
      ST_DR_SH:   nxt = tms ? ST_DR_EX1  : ST_DR_SH;
      ST_DR_EX1:  nxt = tms ? ST_DR_UPD  : ST_DR_PAU;
      ST_DR_PAU:  nxt = tms ? ST_DR_EX2  : ST_DR_PAU;
      ST_DR_EX2:  nxt = tms ? ST_DR_UPD  : ST_DR_SH;
      ST_DR_UPD:  nxt = tms ? ST_DR_SCAN : ST_IDLE;
      ST_IR_SCAN: nxt = tms ? ST_RESET   : ST_IR_CAP;
      ST_IR_CAP:  nxt = tms ? ST_IR_EX1  : ST_IR_SH;
      ST_IR_SH:   nxt = tms ? ST_IR_EX1  : ST_IR_SH;
      ST_IR_EX1:  nxt = tms ? ST_IR_UPD  : ST_IR_PAU;
      ST_IR_PAU:  nxt = tms ? ST_IR_EX2  : ST_IR_PAU;
      ST_IR_EX2:  nxt = tms ? ST_IR_UPD  : ST_IR_SH;
      ST_IR_UPD:  nxt = tms ? ST_DR_SCAN : ST_IDLE;
      default:    nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_RESET;
    else         state <= nxt;
  end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
#(
  parameter int          IR_W      = 3,
  parameter logic [IR_W-1:0] CAPT_PAT  = 3'b101,
  parameter logic [IR_W-1:0] OP_DRIVE  = 3'b000,
  parameter logic [IR_W-1:0] OP_SAMPLE = 3'b101,
  parameter logic [IR_W-1:0] OP_BYPASS = 3'b111
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  tap_state_e      state,
  output logic [IR_W-1:0] ir_sr,
  output logic [IR_W-1:0] ir_lat,
  output tap_ins_e        ins
);

  localparam int TOP = IR_W - 1;

  // capture and shift on the rising edge, LSB leaves first
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sr <= CAPT_PAT;
    end else if (state == ST_IR_CAP) begin
      ir_sr <= CAPT_PAT;
    end else if (state == ST_IR_SH) begin
      ir_sr[TOP] <= tdi;
      for (int i = 0; i < TOP; i++) ir_sr[i] <= ir_sr[i+1];
    end
  end

  // active instruction moves only on the falling edge
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)                  ir_lat <= OP_BYPASS;
    else if (state == ST_RESET)   ir_lat <= OP_BYPASS;
    else if (state == ST_IR_UPD)  ir_lat <= ir_sr;
  end

  always_comb begin
    if (ir_lat == OP_DRIVE)       ins = INS_DRIVE;
    else if (ir_lat == OP_SAMPLE) ins = INS_SAMPLE;
    else                          ins = INS_BYPASS;
  end

endmodule

// File: rtl/tap_dr_path.sv
module tap_dr_path
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tdi,
  input  tap_state_e state,
  input  tap_ins_e   ins,
  input  logic       ir_out,
  input  logic       bsr_tdo,
  output logic       tdo,
  output logic       tdo_en,
  output logic       bsr_select,
  output logic       bsr_capture,
  output logic       bsr_shift,
  output logic       bsr_update,
  output logic       pin_override
);

  logic byp_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                 byp_q <= 1'b0;
    else if (state == ST_DR_CAP) byp_q <= 1'b0;
    else if (state == ST_DR_SH)  byp_q <= tdi;
  end

  assign bsr_select   = (ins == INS_DRIVE) || (ins == INS_SAMPLE);
  assign pin_override = (ins == INS_DRIVE);
  assign bsr_capture  = bsr_select && (state == ST_DR_CAP);
  assign bsr_shift    = bsr_select && (state == ST_DR_SH);
  assign bsr_update   = bsr_select && (state == ST_DR_UPD);

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else if (state == ST_IR_SH) begin
      tdo    <= ir_out;
      tdo_en <= 1'b1;
    end else if (state == ST_DR_SH) begin
      tdo    <= bsr_select ? bsr_tdo : byp_q;
      tdo_en <= 1'b1;
    end else begin
      tdo_en <= 1'b0;
    end
  end

endmodule

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
  import tap_pkg::*;
#(
  parameter int               IR_W      = 3,
  parameter logic [IR_W-1:0]  CAPT_PAT  = 3'b101,
  parameter logic [IR_W-1:0]  OP_DRIVE  = 3'b000,
  parameter logic [IR_W-1:0]  OP_SAMPLE = 3'b101,
  parameter logic [IR_W-1:0]  OP_BYPASS = 3'b111
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  input  logic bsr_tdo,
  output logic tdo,
  output logic tdo_en,
  output logic bsr_select,
  output logic bsr_capture,
  output logic bsr_shift,
  output logic bsr_update,
  output logic pin_override
);

  tap_state_e      cur_state;
  logic [IR_W-1:0] ir_shift;
  logic [IR_W-1:0] ir_active;
  tap_ins_e        cur_ins;

  tap_fsm u_fsm (
    .tck    (tck),
    .trst_n (trst_n),
    .tms    (tms),
    .state  (cur_state)
  );

  tap_ir #(
    .IR_W      (IR_W),
    .CAPT_PAT  (CAPT_PAT),
    .OP_DRIVE  (OP_DRIVE),
    .OP_SAMPLE (OP_SAMPLE),
    .OP_BYPASS (OP_BYPASS)
  ) u_ir (
    .tck    (tck),
    .trst_n (trst_n),
    .tdi    (tdi),
    .state  (cur_state),
    .ir_sr  (ir_shift),
    .ir_lat (ir_active),
    .ins    (cur_ins)
  );

  tap_dr_path u_dr (
    .tck          (tck),
    .trst_n       (trst_n),
    .tdi          (tdi),
    .state        (cur_state),
    .ins          (cur_ins),
    .ir_out       (ir_shift[0]),
    .bsr_tdo      (bsr_tdo),
    .tdo          (tdo),
    .tdo_en       (tdo_en),
    .bsr_select   (bsr_select),
    .bsr_capture  (bsr_capture),
    .bsr_shift    (bsr_shift),
    .bsr_update   (bsr_update),
    .pin_override (pin_override)
  );

endmodule

// File: rtl/jtag_tap_ctrl_chk.sv
module jtag_tap_ctrl_chk
  import tap_pkg::*;
#(
  parameter int              IR_W     = 3,
  parameter logic [IR_W-1:0] CAPT_PAT = 3'b101
) (
  input logic            tck,
  input logic            trst_n,
  input logic            tms,
  input tap_state_e      cur_state,
  input logic [IR_W-1:0] ir_shift,
  input tap_ins_e        cur_ins,
  input logic            tdo_en,
  input logic            bsr_select,
  input logic            bsr_capture,
  input logic            bsr_shift,
  input logic            bsr_update,
  input logic            pin_override
);

  logic [2:0] ones_cnt;
  logic       seen;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ones_cnt <= 3'd0;
      seen     <= 1'b0;
    end else begin
      seen <= 1'b1;
      if (!tms)                 ones_cnt <= 3'd0;
      else if (ones_cnt != 3'd7) ones_cnt <= ones_cnt + 3'd1;
    end
  end

  // R2
  a_r2_capture_pattern: assert property (@(posedge tck) disable iff (!trst_n)
    (cur_state == ST_IR_CAP) |=> (ir_shift == CAPT_PAT));

  // R7
  a_r7_one_strobe: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({bsr_capture, bsr_shift, bsr_update}));

  // R8
  a_r8_valid_in_shift: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en |-> (cur_state == ST_DR_SH || cur_state == ST_IR_SH));

  // R9
  a_r9_five_ones: assert property (@(posedge tck) disable iff (!trst_n)
    (ones_cnt >= 3'd5) |-> (cur_ins == INS_BYPASS && !bsr_select && !pin_override));

  // R10
  a_r10_latch_hold: assert property (@(posedge tck) disable iff (!trst_n)
    (seen && cur_state != ST_IR_UPD && cur_state != ST_RESET) |-> $stable(cur_ins));

endmodule

bind jtag_tap_ctrl jtag_tap_ctrl_chk #(.IR_W(IR_W), .CAPT_PAT(CAPT_PAT)) u_chk (
  .tck          (tck),
  .trst_n       (trst_n),
  .tms          (tms),
  .cur_state    (cur_state),
  .ir_shift     (ir_shift),
  .cur_ins      (cur_ins),
  .tdo_en       (tdo_en),
  .bsr_select   (bsr_select),
  .bsr_capture  (bsr_capture),
  .bsr_shift    (bsr_shift),
  .bsr_update   (bsr_update),
  .pin_override (pin_override)
);

// File: tb/jtag_tap_ctrl_test.sv
`timescale 1ns/1ps
module jtag_tap_ctrl_test;

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic bsr_tdo = 1'b0;
  logic tdo, tdo_en, bsr_select, bsr_capture, bsr_shift, bsr_update, pin_override;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 tck = ~tck;

  jtag_tap_ctrl uut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .bsr_tdo(bsr_tdo),
    .tdo(tdo), .tdo_en(tdo_en), .bsr_select(bsr_select),
    .bsr_capture(bsr_capture), .bsr_shift(bsr_shift),
    .bsr_update(bsr_update), .pin_override(pin_override)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive, one rising edge, then sample just after the falling edge
  task automatic step(input logic m, input logic d, input logic b);
    tms = m; tdi = d; bsr_tdo = b;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic load_ir(input logic [2:0] op);
    step(1, 0, 0); step(1, 0, 0); step(0, 0, 0);
    step(0, 0, 0);
    check("R2 capture bit0", {tdo_en, tdo}, 2'b11);
    step(0, op[0], 0);
    check("R2 capture bit1", {tdo_en, tdo}, 2'b10);
    step(0, op[1], 0);
    check("R2 capture bit2", {tdo_en, tdo}, 2'b11);
    step(1, op[2], 0);
    check("R8 no valid in exit", tdo_en, 1'b0);
    step(1, 0, 0);
    step(0, 0, 0);
  endtask

  // data scan of 4 bits; exp_sel says which register is routed
  task automatic dr_scan(input string req, input logic exp_sel,
                         input logic [3:0] d, input logic [3:0] b);
    step(1, 0, 0);
    step(0, 0, 0);
    check("R7 capture strobe", bsr_capture, exp_sel);
    step(0, 0, b[0]);
    check("R7 shift strobe", bsr_shift, exp_sel);
    check({req, " first bit"}, {tdo_en, tdo}, {1'b1, exp_sel ? b[0] : 1'b0});
    for (int i = 0; i < 3; i++) begin
      step(0, d[i], b[i+1]);
      check({req, " shifted bit"}, tdo, exp_sel ? b[i+1] : d[i]);
    end
    step(1, d[3], 0);
    check("R8 exit stops valid", tdo_en, 1'b0);
    step(1, 0, 0);
    check("R7 update strobe", bsr_update, exp_sel);
    step(0, 0, 0);
    check("R7 idle strobes low", {bsr_capture, bsr_shift, bsr_update}, 3'b000);
  endtask

  task automatic t_reset;
    check("R1 reset outputs", {bsr_select, pin_override, tdo_en,
          bsr_capture, bsr_shift, bsr_update}, 6'b0);
    @(negedge tck); #1;
    trst_n = 1'b1;
    step(0, 0, 0);
  endtask

  task automatic t_drive;
    load_ir(3'b000);
    check("R3 drive select/override", {bsr_select, pin_override}, 2'b11);
    dr_scan("R6 chain to tdo", 1'b1, 4'b0110, 4'b1011);
  endtask

  task automatic t_sample;
    load_ir(3'b101);
    check("R4 sample select/override", {bsr_select, pin_override}, 2'b10);
    dr_scan("R6 sample chain", 1'b1, 4'b1111, 4'b0100);
  endtask

  task automatic t_bypass;
    load_ir(3'b111);
    check("R5 bypass select/override", {bsr_select, pin_override}, 2'b00);
    dr_scan("R5 bypass delay", 1'b0, 4'b1101, 4'b1111);
    foreach (unl[k]) ;
  endtask
  logic [2:0] unl [5] = '{3'b001, 3'b010, 3'b011, 3'b100, 3'b110};

  task automatic t_unlisted;
    for (int k = 0; k < 5; k++) begin
      load_ir(3'b000);
      load_ir(unl[k]);
      check("R5 unlisted acts as bypass", {bsr_select, pin_override}, 2'b00);
    end
    dr_scan("R5 unlisted bypass path", 1'b0, 4'b0101, 4'b1111);
  endtask

  task automatic t_latch_timing;
    load_ir(3'b101);
    step(1, 0, 0); step(1, 0, 0); step(0, 0, 0);
    step(0, 0, 0); step(0, 0, 0); step(0, 0, 0);
    step(1, 0, 0);
    check("R10 hold in exit", pin_override, 1'b0);
    step(0, 0, 0);
    check("R10 hold in pause", pin_override, 1'b0);
    step(1, 0, 0);
    step(1, 0, 0);
    check("R10 takes effect at update", pin_override, 1'b1);
    step(0, 0, 0);
  endtask

  task automatic t_tms_reset;
    load_ir(3'b000);
    step(1, 0, 0); step(0, 0, 0); step(0, 0, 0);
    for (int i = 0; i < 5; i++) step(1, 0, 0);
    check("R9 five ones restore bypass", {bsr_select, pin_override}, 2'b00);
    step(0, 0, 0);
    dr_scan("R9 bypass after reset", 1'b0, 4'b0011, 4'b1111);
  endtask

  task automatic t_async;
    load_ir(3'b000);
    check("R11 drive active", pin_override, 1'b1);
    #0.5 trst_n = 1'b0;
    #0.5;
    check("R11 async clear", {bsr_select, pin_override, tdo_en}, 3'b000);
    @(negedge tck); #1;
    trst_n = 1'b1;
    step(0, 0, 0);
    check("R1 idle after reset", {bsr_select, pin_override}, 2'b00);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #12;
    t_reset();
    t_drive();
    t_sample();
    t_bypass();
    t_unlisted();
    t_latch_timing();
    t_tms_reset();
    t_async();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule